// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a nibble-organised flash memory. It watches a simple clocked host bus (chip enable, write strobe, read strobe, address, write data) and turns command bytes into work for the storage array. Erase and program each need a setup byte and a second confirming write. Verify, attribute-space selection and identification each take one byte, and a reset byte backs out of any of them. The array is seen only through a one-cycle request pulse that carries an operation code, address, data and space select, an abort pulse, and a read-data input.

An internal timer sized in clock cycles keeps the controller busy while an erase or program runs. During that window, host reads return status instead of stored data. The polling bits (3 and 7) carry the complement of the value being written at the last written address, and the toggle bits (2 and 6) flip on every read. A write-protect pin and a software-lock input block every command that would change the array. Reads keep working while either is high.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The byte 22h followed by DDh starts an erase. After the DDh write, `arr_req` pulses for one cycle with `arr_op` = 1 and `arr_addr` equal to the DDh write's address, and `busy` stays high for exactly ERASE_CYC cycles.
- R2: The byte 11h followed by any other write starts a program. That write's address and data appear on `arr_addr` and `arr_wdata` with `arr_op` = 2 and a one-cycle `arr_req`, and `busy` stays high for exactly PROG_CYC cycles.
- R3: Writing FFh directly after either setup byte issues no request and leaves `busy` low. It returns the controller to plain reads and clears attribute mode.
- R4: After 88h, `rd_attr` and `arr_attr` are high whatever `space_attr_in` is, until FFh is written. In plain mode `rd_attr` follows `space_attr_in`.
- R5: After 99h, reads return BFh at address 0, 11h at address 1 and 00h elsewhere. Any other recognised command ends this mode.
- R6: The byte AAh issues a one-cycle `arr_req` with `arr_op` = 3 at that write's address, without raising `busy`.
- R7: FFh written during an erase pulses `arr_abort` and drops `busy` at the same edge. During a program, FFh is ignored and `busy` stays high.
- R8: While busy, a read of the last written address returns that byte with bits 3 and 7 inverted. For an erase, the byte is FFh. Reads of any other address return the array data on those bits.
- R9: While busy, bits 2 and 6 of every read carry a toggle value. The toggle is 0 on the first read after the operation starts and inverts on each later read.
- R10: While `wp` or `sw_lock` is high, the setup bytes and the confirming writes issue no erase or program request and leave `busy` low.
- R11: A byte that is not a known command, or a confirming write that does not match its setup, leaves the controller in plain read mode with no request.
- R12: Out of reset `busy`, `arr_req`, `arr_abort` and `rd_valid` are low. A plain read returns `arr_rdata`.
- R13: Every read strobe with chip enable high yields exactly one `rd_valid` pulse on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Chip enable for the host cycle |
| bus_wr | input | 1 | Host write strobe (command or data byte) |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | AW | Host address |
| bus_wdata | input | 8 | Host write byte |
| space_attr_in | input | 1 | High selects attribute space when attribute mode is off |
| wp | input | 1 | Hardware write protect, high blocks changes |
| sw_lock | input | 1 | Software protection state, high blocks changes |
| arr_req | output | 1 | One-cycle array request |
| arr_op | output | 2 | Request kind: 1 erase, 2 program, 3 verify |
| arr_abort | output | 1 | One-cycle erase abort |
| arr_addr | output | AW | Request address |
| arr_wdata | output | 8 | Request data (FFh for erase) |
| arr_attr | output | 1 | Request targets attribute space |
| arr_rdata | input | 8 | Array byte at `bus_addr` during a read strobe |
| rd_attr | output | 1 | Space used for current reads |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Erase or program in progress |

## Verification
The command decoder is driven with complete erase and program sequences, with each sequence cut short by FFh, and with mismatched or unknown second bytes. Together these show whether a request comes only from a full two-step sequence. Busy-window reads alternate between the last written address and another address, so polling inversion, which depends on the address, can be told apart from toggling, which applies to every read. The protect inputs are raised before a setup byte and also between setup and confirm. This shows whether the guard is applied at both steps.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
    localparam logic [7:0] CMD_ERS_SETUP = 8'h22;
    localparam logic [7:0] CMD_ERS_GO    = 8'hDD;
    localparam logic [7:0] CMD_PRG_SETUP = 8'h11;
    localparam logic [7:0] CMD_RESET     = 8'hFF;
    localparam logic [7:0] CMD_ATTR      = 8'h88;
    localparam logic [7:0] CMD_IDENT     = 8'h99;
    localparam logic [7:0] CMD_VERIFY    = 8'hAA;
    localparam logic [7:0] ID_MAKER      = 8'hBF;
    localparam logic [7:0] ID_DEVICE     = 8'h11;
    localparam logic [7:0] POLL_MASK     = 8'h88;

    typedef enum logic [2:0] {
        ST_READ, ST_ERS_SETUP, ST_PRG_SETUP, ST_ERS_BUSY, ST_PRG_BUSY
    } fsm_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0, OP_ERASE = 2'd1, OP_PROG = 2'd2, OP_VERIFY = 2'd3
    } arr_op_t;
endpackage

// File: rtl/flash_op_timer.sv
`timescale 1ns/1ps
module flash_op_timer
    import flash_cmd_pkg::*;
#(
    parameter int ERASE_CYC = 100000,
    parameter int PROG_CYC  = 1750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_erase,
    input  logic start_prog,
    input  logic kill,
    output logic done
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (kill) begin
            tmr_d.run = 1'b0;
        end else if (start_erase) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CW'(ERASE_CYC);
        end else if (start_prog) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CW'(PROG_CYC);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == CW'(1)) tmr_d.run = 1'b0;
            else                     tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done = tmr_q.run && (tmr_q.cnt == CW'(1));
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          space_in,
    input  logic          protect,
    input  logic          tdone,
    output logic          start_erase,
    output logic          start_prog,
    output logic          kill,
    output logic          busy,
    output logic          req,
    output logic [1:0]    op,
    output logic          abort,
    output logic [AW-1:0] req_addr,
    output logic [7:0]    req_data,
    output logic          req_attr,
    output logic          attr_mode,
    output logic          id_mode,
    output logic          tog
);
    typedef struct packed {
        fsm_state_t    st;
        logic          attr;
        logic          id;
        logic          req;
        arr_op_t       op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          rattr;
        logic          abort;
        logic          tog;
    } ctl_t;

    ctl_t c_d, c_q;
    logic space_eff;

    always_comb begin
        c_d         = c_q;
        c_d.req     = 1'b0;
        c_d.abort   = 1'b0;
        start_erase = 1'b0;
        start_prog  = 1'b0;
        kill        = 1'b0;
        space_eff   = c_q.attr | space_in;
        unique case (c_q.st)
            ST_READ: begin
                if (wr_stb) begin
                    unique case (wdata)
                        CMD_ERS_SETUP: begin
                            c_d.id = 1'b0;
                            if (!protect) c_d.st = ST_ERS_SETUP;
                        end
                        CMD_PRG_SETUP: begin
                            c_d.id = 1'b0;
                            if (!protect) c_d.st = ST_PRG_SETUP;
                        end
                        CMD_RESET: begin
                            c_d.id   = 1'b0;
                            c_d.attr = 1'b0;
                        end
                        CMD_ATTR: begin
                            c_d.id   = 1'b0;
                            c_d.attr = 1'b1;
                        end
                        CMD_IDENT: c_d.id = 1'b1;
                        CMD_VERIFY: begin
                            c_d.id    = 1'b0;
                            c_d.req   = 1'b1;
                            c_d.op    = OP_VERIFY;
                            c_d.addr  = addr;
                            c_d.rattr = space_eff;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ERS_SETUP: begin
                if (wr_stb) begin
                    if (wdata == CMD_ERS_GO && !protect) begin
                        c_d.st      = ST_ERS_BUSY;
                        c_d.req     = 1'b1;
                        c_d.op      = OP_ERASE;
                        c_d.addr    = addr;
                        c_d.data    = 8'hFF;
                        c_d.rattr   = space_eff;
                        c_d.tog     = 1'b0;
                        start_erase = 1'b1;
                    end else begin
                        c_d.st = ST_READ;
                        if (wdata == CMD_RESET) c_d.attr = 1'b0;
                    end
                end
            end
            ST_PRG_SETUP: begin
                if (wr_stb) begin
                    if (wdata == CMD_RESET) begin
                        c_d.st   = ST_READ;
                        c_d.attr = 1'b0;
                    end else if (protect) begin
                        c_d.st = ST_READ;
                    end else begin
                        c_d.st     = ST_PRG_BUSY;
                        c_d.req    = 1'b1;
                        c_d.op     = OP_PROG;
                        c_d.addr   = addr;
                        c_d.data   = wdata;
                        c_d.rattr  = space_eff;
                        c_d.tog    = 1'b0;
                        start_prog = 1'b1;
                    end
                end
            end
            ST_ERS_BUSY: begin
                if (rd_stb) c_d.tog = ~c_q.tog;
                if (wr_stb && wdata == CMD_RESET) begin
                    c_d.st    = ST_READ;
                    c_d.abort = 1'b1;
                    c_d.attr  = 1'b0;
                    kill      = 1'b1;
                end else if (tdone) begin
                    c_d.st = ST_READ;
                end
            end
            ST_PRG_BUSY: begin
                if (rd_stb) c_d.tog = ~c_q.tog;
                if (tdone) c_d.st = ST_READ;
            end
            default: c_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_READ;
            c_q.op <= OP_NONE;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy      = (c_q.st == ST_ERS_BUSY) || (c_q.st == ST_PRG_BUSY);
    assign req       = c_q.req;
    assign op        = c_q.op;
    assign abort     = c_q.abort;
    assign req_addr  = c_q.addr;
    assign req_data  = c_q.data;
    assign req_attr  = c_q.rattr;
    assign attr_mode = c_q.attr;
    assign id_mode   = c_q.id;
    assign tog       = c_q.tog;
endmodule

// File: rtl/flash_rd_path.sv
`timescale 1ns/1ps
module flash_rd_path
    import flash_cmd_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    arr_rdata,
    input  logic          busy,
    input  logic          id_mode,
    input  logic [AW-1:0] last_addr,
    input  logic [7:0]    last_data,
    input  logic          tog,
    output logic          rd_valid,
    output logic [7:0]    rd_data
);
    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } rd_t;

    rd_t  r_d, r_q;
    logic [7:0] val;

    always_comb begin
        if (busy) begin
            val    = (addr == last_addr) ? (last_data ^ POLL_MASK) : arr_rdata;
            val[2] = tog;
            val[6] = tog;
        end else if (id_mode) begin
            if (addr == AW'(0))      val = ID_MAKER;
            else if (addr == AW'(1)) val = ID_DEVICE;
            else                     val = 8'h00;
        end else begin
            val = arr_rdata;
        end
        r_d.vld  = rd_stb;
        r_d.data = rd_stb ? val : r_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.vld;
    assign rd_data  = r_q.data;
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 20,
    parameter int ERASE_CYC = 100000,
    parameter int PROG_CYC  = 1750
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          space_attr_in,
    input  logic          wp,
    input  logic          sw_lock,
    output logic          arr_req,
    output logic [1:0]    arr_op,
    output logic          arr_abort,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata,
    output logic          arr_attr,
    input  logic [7:0]    arr_rdata,
    output logic          rd_attr,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          busy
);
    logic wr_stb, rd_stb, protect;
    logic t_start_e, t_start_p, t_kill, t_done;
    logic attr_mode, id_mode, tog;

    assign wr_stb  = bus_cs & bus_wr;
    assign rd_stb  = bus_cs & bus_rd;
    assign protect = wp | sw_lock;

    flash_cmd_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .space_in   (space_attr_in),
        .protect    (protect),
        .tdone      (t_done),
        .start_erase(t_start_e),
        .start_prog (t_start_p),
        .kill       (t_kill),
        .busy       (busy),
        .req        (arr_req),
        .op         (arr_op),
        .abort      (arr_abort),
        .req_addr   (arr_addr),
        .req_data   (arr_wdata),
        .req_attr   (arr_attr),
        .attr_mode  (attr_mode),
        .id_mode    (id_mode),
        .tog        (tog)
    );

    flash_op_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_erase(t_start_e),
        .start_prog (t_start_p),
        .kill       (t_kill),
        .done       (t_done)
    );

    flash_rd_path #(.AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .addr     (bus_addr),
        .arr_rdata(arr_rdata),
        .busy     (busy),
        .id_mode  (id_mode),
        .last_addr(arr_addr),
        .last_data(arr_wdata),
        .tog      (tog),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign rd_attr = attr_mode | space_attr_in;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_cs,
    input logic       bus_rd,
    input logic       wp,
    input logic       sw_lock,
    input logic       arr_req,
    input logic [1:0] arr_op,
    input logic       arr_abort,
    input logic       busy,
    input logic       rd_valid
);
    // R1 / R2: a busy window opens only together with an erase or program request
    assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (arr_req && (arr_op == 2'd1 || arr_op == 2'd2)));

    // R6: any request carries a real operation code
    assert_req_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> (arr_op != 2'd0));

    // R7: abort only ends a running operation and closes the busy window
    assert_abort_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_abort |-> (!busy && $past(busy)));

    // R10: protect inputs suppress altering requests
    assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wp || sw_lock) |=> !(arr_req && arr_op != 2'd3));

    // R13: a read strobe is answered on the next cycle, and only then
    assert_rd_answer_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_rd) |=> rd_valid);
    assert_rd_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_cs && bus_rd));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs   (bus_cs),
    .bus_rd   (bus_rd),
    .wp       (wp),
    .sw_lock  (sw_lock),
    .arr_req  (arr_req),
    .arr_op   (arr_op),
    .arr_abort(arr_abort),
    .busy     (busy),
    .rd_valid (rd_valid)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
    localparam int AW   = 20;
    localparam int ECYC = 20;
    localparam int PCYC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          space_attr_in = 1'b0, wp = 1'b0, sw_lock = 1'b0;
    logic          arr_req, arr_abort, arr_attr, rd_attr, rd_valid, busy;
    logic [1:0]    arr_op;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata, arr_rdata, rd_data;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    // simple array model: data is a function of the address
    assign arr_rdata = bus_addr[7:0] ^ 8'h5A;

    flash_cmd_ctrl #(.AW(AW), .ERASE_CYC(ECYC), .PROG_CYC(PCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .space_attr_in(space_attr_in),
        .wp(wp), .sw_lock(sw_lock), .arr_req(arr_req), .arr_op(arr_op),
        .arr_abort(arr_abort), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_attr(arr_attr), .arr_rdata(arr_rdata), .rd_attr(rd_attr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // monitor: compare every returned read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R13", rd_data, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    bit finished = 1'b0;
    initial begin
        #(20 * 100000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check(!busy && !arr_req && !arr_abort && !rd_valid, "R12", {busy, arr_req, arr_abort, rd_valid}, 0);
        space_attr_in = 1'b1;
        #1 check(rd_attr == 1'b1, "R4", rd_attr, 1);
        space_attr_in = 1'b0;
        rd(20'h00123, 8'h23 ^ 8'h5A, "R12");

        // R1 erase sequence and busy length
        wr(20'h00100, 8'h22);
        check(!arr_req && !busy, "R1", {arr_req, busy}, 0);
        wr(20'h00345, 8'hDD);
        check(arr_req && arr_op == 2'd1 && arr_addr == 20'h00345 && arr_wdata == 8'hFF,
              "R1", {arr_req, arr_op}, 32'h5);
        count_busy(n);
        check(n == ECYC, "R1", n, ECYC);
        rd(20'h00345, 8'h45 ^ 8'h5A, "R1");

        // R8 / R9 status during erase, then R7 abort
        wr(20'h0, 8'h22);
        wr(20'h00400, 8'hDD);
        rd(20'h00400, 8'h33, "R8");
        rd(20'h00400, 8'h77, "R9");
        rd(20'h00010, 8'h0A, "R9");
        wr(20'h0, 8'hFF);
        check(arr_abort == 1'b1 && busy == 1'b0, "R7", {arr_abort, busy}, 2);

        // R2 program, status reads, FF ignored while programming
        wr(20'h0, 8'h11);
        wr(20'h00222, 8'hC5);
        check(arr_req && arr_op == 2'd2 && arr_addr == 20'h00222 && arr_wdata == 8'hC5 && busy,
              "R2", {arr_op, arr_wdata}, 32'h2C5);
        rd(20'h00222, 8'h09, "R8");
        rd(20'h00222, 8'h4D, "R9");
        wr(20'h0, 8'hFF);
        check(busy == 1'b1 && arr_abort == 1'b0, "R7", {busy, arr_abort}, 2);
        count_busy(n);
        rd(20'h00222, 8'h22 ^ 8'h5A, "R2");
        wr(20'h0, 8'h11);
        wr(20'h00050, 8'h3C);
        count_busy(n);
        check(n == PCYC, "R2", n, PCYC);

        // R3 aborting from each setup
        wr(20'h0, 8'h88);
        check(rd_attr == 1'b1, "R4", rd_attr, 1);
        wr(20'h0, 8'h22);
        wr(20'h0, 8'hFF);
        check(!arr_req && !busy && !rd_attr, "R3", {arr_req, busy, rd_attr}, 0);
        wr(20'h0, 8'h11);
        wr(20'h00066, 8'hFF);
        check(!arr_req && !busy, "R3", {arr_req, busy}, 0);
        rd(20'h00005, 8'h05 ^ 8'h5A, "R3");

        // R4 attribute mode carried on the erase request
        wr(20'h0, 8'h88);
        wr(20'h0, 8'h22);
        wr(20'h00200, 8'hDD);
        check(arr_req && arr_attr, "R4", {arr_req, arr_attr}, 3);
        wr(20'h0, 8'hFF);
        check(!rd_attr, "R4", rd_attr, 0);

        // R5 identification mode
        wr(20'h0, 8'h99);
        rd(20'h00000, 8'hBF, "R5");
        rd(20'h00001, 8'h11, "R5");
        rd(20'h00002, 8'h00, "R5");
        wr(20'h0, 8'h88);
        rd(20'h00000, 8'h5A, "R5");
        wr(20'h0, 8'hFF);

        // R6 verify
        wr(20'h00077, 8'hAA);
        check(arr_req && arr_op == 2'd3 && arr_addr == 20'h00077 && !busy, "R6", {arr_req, arr_op}, 7);

        // R10 protection
        wp = 1'b1;
        wr(20'h0, 8'h22);
        wr(20'h00300, 8'hDD);
        check(!arr_req && !busy, "R10", {arr_req, busy}, 0);
        wr(20'h0, 8'h11);
        wr(20'h00300, 8'h00);
        check(!arr_req && !busy, "R10", {arr_req, busy}, 0);
        rd(20'h00031, 8'h31 ^ 8'h5A, "R10");
        wp = 1'b0;
        sw_lock = 1'b1;
        wr(20'h0, 8'h22);
        wr(20'h00300, 8'hDD);
        check(!arr_req && !busy, "R10", {arr_req, busy}, 0);
        sw_lock = 1'b0;
        wr(20'h0, 8'h22);
        wp = 1'b1;
        wr(20'h00300, 8'hDD);
        check(!arr_req && !busy, "R10", {arr_req, busy}, 0);
        wp = 1'b0;

        // R11 mismatch and unknown bytes
        wr(20'h0, 8'h22);
        wr(20'h0, 8'h11);
        wr(20'h00300, 8'hDD);
        check(!arr_req && !busy, "R11", {arr_req, busy}, 0);
        wr(20'h0, 8'h5C);
        wr(20'h00300, 8'hDD);
        check(!arr_req && !busy, "R11", {arr_req, busy}, 0);
        rd(20'h00044, 8'h44 ^ 8'h5A, "R11");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R13", exp_q.size(), 0);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule